// File: doc/BRIEF.md
# Nonvolatile Memory Control Register Sequencer

This block is the control byte and operation sequencer that sits between a CPU register port and an on-chip nonvolatile store. Software writes one eight-bit control byte to pick a target space (data array, program array or configuration space) and to start a read, a row erase or a write. The block turns an accepted start into a one-cycle request toward the memory side, tracks the self-timed write or erase until the memory returns done, and clears the command bits itself when the work is finished.

The command bits are set-only from software. A write start needs write enable to already be set, and a read is refused unless both select bits are 0. While a write or erase is in flight, the select bits and the row-erase bit are frozen. A warm abort that lands during a write or erase ends it early, raises a sticky error flag and leaves the select bits in place, so software can still see which operation failed.

Top module: `nvm_ctl_seq`

## Requirements
- R1: On a power-on reset (`rst_n` low at a clock edge), `reg_rdata` reads 0x00, and `busy` and `mem_req` are 0.
- R2: Control byte layout: bit 7 selects the program array, bit 6 selects the configuration space, bit 5 always reads 0, bit 4 is row-erase enable, bit 3 is the error flag, bit 2 is write enable, bit 1 is write start and bit 0 is read start. While idle, bits 7, 6, 4, 3 and 2 read back the value last written.
- R3: A write start (bit 1 written as 1) is accepted only if write enable already read 1 before that register write and no operation is active. A refused start leaves bit 1 at 0, `busy` at 0 and issues no request.
- R4: An accepted write start sets bit 1 and `busy` in the next cycle. In the same cycle `mem_req` is high for exactly one cycle, with `mem_op` = 2 (erase) if the row-erase bit as written is 1 and 1 (write) otherwise, and `mem_addr` equal to `tbl_addr` at the register write.
- R5: `mem_done` while busy clears bit 1 and `busy` in the next cycle, and also clears the row-erase bit if the operation was an erase. `mem_done` while idle has no effect.
- R6: A read start (bit 0) is accepted when no operation is active and both select bits, as they stand after that write, are 0. Bit 0 reads 1 and `mem_req` pulses with `mem_op` = 0 and `mem_space` = 0 for one cycle. In the next cycle bit 0 reads 0 and `rd_data` holds the `mem_rdata` value from the request cycle.
- R7: A read start is refused (bit 0 stays 0, no request, `rd_data` unchanged) while either select bit is 1. When a write start is accepted in the same register write, the read start is dropped.
- R8: Software cannot clear bit 1 or bit 0. Writing 0 to them leaves a running operation in progress.
- R9: While `busy` is 1, writes to bits 7, 6 and 4 are ignored. Bits 2 and 3 remain writable.
- R10: `abort_i` while busy clears `busy` and bit 1 in the next cycle and sets the error flag, keeping bits 7, 6 and 4. Abort takes priority over a same-cycle `mem_done`. Abort while idle has no effect.
- R11: The error flag is cleared only by a software write of 0 to bit 3 or by power-on reset. A hardware set wins over a same-cycle software write.
- R12: `mem_space` encoding for a write or erase: 2 when the configuration select bit is 1 (whatever bit 7 holds), 1 when only the program select bit is 1, 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| abort_i | input | 1 | Warm abort of a running write or erase |
| reg_wr_en | input | 1 | CPU write strobe for the control byte |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | Current control byte |
| tbl_addr | input | ADDR_W | Table address of the target row or location |
| busy | output | 1 | Write or erase in progress |
| mem_req | output | 1 | One-cycle request toward the memory |
| mem_op | output | 2 | Operation: 0 read, 1 write, 2 erase |
| mem_space | output | 2 | Target: 0 data, 1 program, 2 configuration |
| mem_addr | output | ADDR_W | Address captured with the request |
| mem_done | input | 1 | Completion pulse from the memory |
| mem_rdata | input | DATA_W | Read data, valid while a read request is out |
| rd_data | output | DATA_W | Captured read data |

## Verification
If the sequencer state is wrong, the bits in `reg_rdata` go wrong one cycle after the cause. Examples are a write start that stays set after done, an error flag missing after an abort, or select bits that move while busy. A bad gating decision shows up the same cycle as an extra or missing `mem_req` pulse, or as the wrong `mem_op`/`mem_space` code. A read captured from the wrong cycle shows up in `rd_data` one cycle after the request. Because every output is registered, a per-cycle comparison against a requirement-level model catches each of these within one clock.

// File: rtl/nvm_seq_pkg.sv
// Shared types and control-byte bit positions for the nonvolatile memory
// sequencer. Assumes an eight-bit control byte whose bit order is fixed,
// since software decodes it.
package nvm_seq_pkg;

    localparam int CTL_W     = 8;
    localparam int BIT_PROG  = 7;
    localparam int BIT_CFG   = 6;
    localparam int BIT_ERASE = 4;
    localparam int BIT_ERR   = 3;
    localparam int BIT_WEN   = 2;
    localparam int BIT_GOW   = 1;
    localparam int BIT_GOR   = 0;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_ERASE = 2'd2
    } nvm_op_e;

    typedef enum logic [1:0] {
        SP_DATA = 2'd0,
        SP_PROG = 2'd1,
        SP_CFG  = 2'd2
    } nvm_space_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic sel_prog;
        logic sel_cfg;
        logic erase_en;
        logic err;
        logic wr_allow;
    } ctl_fields_t;

endpackage

// File: rtl/nvm_cmd_gate.sv
// Command gating: decides, for the current CPU write, which fields may change
// and whether a read or write start is accepted. Purely combinational.
// Assumes `active` covers both an in-flight write and a pending read.
module nvm_cmd_gate
    import nvm_seq_pkg::*;
(
    input  logic                 reg_wr_en,
    input  logic [CTL_W-1:0]     reg_wdata,
    input  ctl_fields_t          fields,
    input  logic                 busy,
    input  logic                 active,
    output logic                 upd_sel,
    output logic                 nxt_prog,
    output logic                 nxt_cfg,
    output logic                 nxt_erase,
    output logic                 start_write,
    output logic                 start_read,
    output nvm_op_e              start_op,
    output nvm_space_e           start_space
);

    // Select and erase fields as they would stand after this write.
    always_comb begin
        upd_sel   = reg_wr_en && !busy;
        nxt_prog  = upd_sel ? reg_wdata[BIT_PROG]  : fields.sel_prog;
        nxt_cfg   = upd_sel ? reg_wdata[BIT_CFG]   : fields.sel_cfg;
        nxt_erase = upd_sel ? reg_wdata[BIT_ERASE] : fields.erase_en;
    end

    // Start acceptance: write needs prior enable; read needs data space.
    always_comb begin
        start_write = reg_wr_en && reg_wdata[BIT_GOW] && fields.wr_allow && !active;
        start_read  = reg_wr_en && reg_wdata[BIT_GOR] && !nxt_prog && !nxt_cfg
                      && !active && !start_write;
    end

    // Operation and space codes carried with the request.
    always_comb begin
        if (nxt_cfg)       start_space = SP_CFG;
        else if (nxt_prog) start_space = SP_PROG;
        else               start_space = SP_DATA;
        if (start_write)   start_op = nxt_erase ? OP_ERASE : OP_WRITE;
        else               start_op = OP_READ;
    end

endmodule

// File: rtl/nvm_ctl_reg.sv
// Holds the software-visible control fields other than the command bits.
// Assumes the gate has already suppressed select/erase updates while busy and
// that fin_erase pulses only when an erase completes without abort.
module nvm_ctl_reg
    import nvm_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [CTL_W-1:0] reg_wdata,
    input  logic             upd_sel,
    input  logic             nxt_prog,
    input  logic             nxt_cfg,
    input  logic             nxt_erase,
    input  logic             busy,
    input  logic             abort_i,
    input  logic             fin_erase,
    output ctl_fields_t      fields
);

    // Field update with hardware events taking priority over software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields <= '0;
        end else begin
            if (upd_sel) begin
                fields.sel_prog <= nxt_prog;
                fields.sel_cfg  <= nxt_cfg;
            end
            if (fin_erase)    fields.erase_en <= 1'b0;
            else if (upd_sel) fields.erase_en <= nxt_erase;
            if (reg_wr_en)    fields.wr_allow <= reg_wdata[BIT_WEN];
            if (busy && abort_i) fields.err <= 1'b1;
            else if (reg_wr_en)  fields.err <= reg_wdata[BIT_ERR];
        end
    end

    assert_abort_sets_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort_i) |=> fields.err);

    assert_sel_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(fields.sel_prog) && $stable(fields.sel_cfg)));

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fields.err && !reg_wr_en) |=> fields.err);

endmodule

// File: rtl/nvm_seq_fsm.sv
// Busy state machine and memory-side request register. A read lasts one
// cycle and captures mem_rdata on exit; a write or erase waits for mem_done
// or abort. Assumes starts are only asserted while the machine is idle.
module nvm_seq_fsm
    import nvm_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_write,
    input  logic              start_read,
    input  nvm_op_e           start_op,
    input  nvm_space_e        start_space,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic              mem_done,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              abort_i,
    output logic              go_write,
    output logic              go_read,
    output logic              busy,
    output logic              active,
    output logic              mem_req,
    output nvm_op_e           mem_op,
    output nvm_space_e        mem_space,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              fin_erase
);

    seq_state_e state;
    logic       wr_finish;

    // Decoded state views used by the register and gate.
    always_comb begin
        go_write  = (state == ST_WRITE);
        go_read   = (state == ST_READ);
        busy      = go_write;
        active    = (state != ST_IDLE);
        wr_finish = busy && mem_done && !abort_i;
        fin_erase = wr_finish && (mem_op == OP_ERASE);
    end

    // Request pulse and captured operation descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req   <= 1'b0;
            mem_op    <= OP_READ;
            mem_space <= SP_DATA;
            mem_addr  <= '0;
        end else begin
            mem_req <= start_write || start_read;
            if (start_write || start_read) begin
                mem_op    <= start_op;
                mem_space <= start_space;
                mem_addr  <= tbl_addr;
            end
        end
    end

    // State sequencing and read data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            rd_data <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_write)     state <= ST_WRITE;
                    else if (start_read) state <= ST_READ;
                end
                ST_READ: begin
                    rd_data <= mem_rdata;
                    state   <= ST_IDLE;
                end
                ST_WRITE: begin
                    if (abort_i || mem_done) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_req_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_busy_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(rst_n)) |-> $past(mem_done || abort_i));

    assert_read_one_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        go_read |=> !go_read);

    assert_read_data_space_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_op == OP_READ) |-> (mem_space == SP_DATA));

endmodule

// File: rtl/nvm_ctl_seq.sv
// Top of the nonvolatile memory control sequencer: CPU control byte, command
// gating, busy tracking and the request/done handshake toward the memory.
// Assumes mem_rdata is valid combinationally while a read request is out.
module nvm_ctl_seq
    import nvm_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_i,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [ADDR_W-1:0] tbl_addr,
    output logic              busy,
    output logic              mem_req,
    output logic [1:0]        mem_op,
    output logic [1:0]        mem_space,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_done,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] rd_data
);

    ctl_fields_t fields;
    logic        upd_sel, nxt_prog, nxt_cfg, nxt_erase;
    logic        start_write, start_read, active, go_write, go_read, fin_erase;
    nvm_op_e     start_op, op_q;
    nvm_space_e  start_space, space_q;

    nvm_cmd_gate u_gate (
        .reg_wr_en   (reg_wr_en),
        .reg_wdata   (reg_wdata),
        .fields      (fields),
        .busy        (busy),
        .active      (active),
        .upd_sel     (upd_sel),
        .nxt_prog    (nxt_prog),
        .nxt_cfg     (nxt_cfg),
        .nxt_erase   (nxt_erase),
        .start_write (start_write),
        .start_read  (start_read),
        .start_op    (start_op),
        .start_space (start_space)
    );

    nvm_ctl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .upd_sel   (upd_sel),
        .nxt_prog  (nxt_prog),
        .nxt_cfg   (nxt_cfg),
        .nxt_erase (nxt_erase),
        .busy      (busy),
        .abort_i   (abort_i),
        .fin_erase (fin_erase),
        .fields    (fields)
    );

    nvm_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_write (start_write),
        .start_read  (start_read),
        .start_op    (start_op),
        .start_space (start_space),
        .tbl_addr    (tbl_addr),
        .mem_done    (mem_done),
        .mem_rdata   (mem_rdata),
        .abort_i     (abort_i),
        .go_write    (go_write),
        .go_read     (go_read),
        .busy        (busy),
        .active      (active),
        .mem_req     (mem_req),
        .mem_op      (op_q),
        .mem_space   (space_q),
        .mem_addr    (mem_addr),
        .rd_data     (rd_data),
        .fin_erase   (fin_erase)
    );

    assign mem_op    = op_q;
    assign mem_space = space_q;

    // Assemble the software-visible control byte.
    always_comb begin
        reg_rdata            = '0;
        reg_rdata[BIT_PROG]  = fields.sel_prog;
        reg_rdata[BIT_CFG]   = fields.sel_cfg;
        reg_rdata[BIT_ERASE] = fields.erase_en;
        reg_rdata[BIT_ERR]   = fields.err;
        reg_rdata[BIT_WEN]   = fields.wr_allow;
        reg_rdata[BIT_GOW]   = go_write;
        reg_rdata[BIT_GOR]   = go_read;
    end

    assert_wr_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(reg_wr_en && reg_wdata[BIT_GOW] && fields.wr_allow)) |=> !busy);

    assert_busy_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_req && mem_op != 2'd0));

endmodule

// File: tb/nvm_ctl_seq_tb.sv
module nvm_ctl_seq_tb;
    localparam int AW = 12;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          abort_i = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [AW-1:0] tbl_addr = '0;
    logic          busy, mem_req;
    logic [1:0]    mem_op, mem_space;
    logic [AW-1:0] mem_addr;
    logic          mem_done = 1'b0;
    logic [DW-1:0] mem_rdata, rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] memf(input logic [AW-1:0] a);
        return a[7:0] ^ 8'hA5 ^ {a[11:8], a[11:8]};
    endfunction

    assign mem_rdata = memf(mem_addr);

    nvm_ctl_seq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .abort_i(abort_i), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tbl_addr(tbl_addr),
        .busy(busy), .mem_req(mem_req), .mem_op(mem_op), .mem_space(mem_space),
        .mem_addr(mem_addr), .mem_done(mem_done), .mem_rdata(mem_rdata),
        .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Requirement-level reference model, advanced at each rising edge.
    logic          m_p, m_c, m_er, m_err, m_wen, m_req;
    logic [1:0]    m_st, m_op, m_sp;
    logic [AW-1:0] m_addr;
    logic [7:0]    m_rd;
    logic          m_live = 1'b0;

    function automatic logic [1:0] space_of(input logic c, input logic p);
        return c ? 2'd2 : (p ? 2'd1 : 2'd0);
    endfunction

    always @(posedge clk) begin
        logic b, act, np, nc, ne, sw, sr;
        if (!rst_n) begin
            m_p <= 0; m_c <= 0; m_er <= 0; m_err <= 0; m_wen <= 0; m_req <= 0;
            m_st <= 0; m_op <= 0; m_sp <= 0; m_addr <= '0; m_rd <= '0;
            m_live <= 1'b1;
        end else begin
            b   = (m_st == 2);
            act = (m_st != 0);
            np  = (reg_wr_en && !b) ? reg_wdata[7] : m_p;
            nc  = (reg_wr_en && !b) ? reg_wdata[6] : m_c;
            ne  = (reg_wr_en && !b) ? reg_wdata[4] : m_er;
            sw  = reg_wr_en && reg_wdata[1] && m_wen && !act;
            sr  = reg_wr_en && reg_wdata[0] && !np && !nc && !act && !sw;
            m_p <= np; m_c <= nc;
            m_req <= sw || sr;
            if (sw) begin m_op <= ne ? 2'd2 : 2'd1; m_sp <= space_of(nc, np); m_addr <= tbl_addr; end
            if (sr) begin m_op <= 2'd0; m_sp <= 2'd0; m_addr <= tbl_addr; end
            if (b && mem_done && !abort_i && m_op == 2'd2) m_er <= 1'b0;
            else m_er <= ne;
            if (reg_wr_en) m_wen <= reg_wdata[2];
            if (b && abort_i) m_err <= 1'b1;
            else if (reg_wr_en) m_err <= reg_wdata[3];
            if (m_st == 1) m_rd <= memf(m_addr);
            if (m_st == 0) m_st <= sw ? 2'd2 : (sr ? 2'd1 : 2'd0);
            else if (m_st == 1) m_st <= 2'd0;
            else if (abort_i || mem_done) m_st <= 2'd0;
        end
    end

    // Per-cycle comparison of registered outputs against the model.
    always @(negedge clk) begin
        if (m_live && rst_n) begin
            chk("R2 model reg_rdata", reg_rdata,
                {m_p, m_c, 1'b0, m_er, m_err, m_wen, m_st == 2, m_st == 1});
            chk("R4 model busy", busy, m_st == 2);
            chk("R4 model mem_req", mem_req, m_req);
            chk("R6 model rd_data", rd_data, m_rd);
            if (m_req) chk("R12 model op/space/addr", {mem_op, mem_space, mem_addr},
                           {m_op, m_sp, m_addr});
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic sw_write(input logic [7:0] d);
        reg_wr_en = 1'b1; reg_wdata = d;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired (all requirements) actual=%0d expected<150000", cycles);
            finish_run();
        end
    end

    initial begin
        int hold;
        void'($urandom(32'd20240611));
        repeat (3) tick();
        chk("R1 reset rdata", reg_rdata, 8'h00);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset req", mem_req, 0);
        rst_n = 1'b1;
        tick();

        sw_write(8'hFF);
        chk("R2 layout bit5 zero", reg_rdata, 8'hDC);
        chk("R3 start refused without enable", busy, 0);
        chk("R7 read refused with selects", mem_req, 0);
        sw_write(8'h04);
        chk("R2 readback", reg_rdata, 8'h04);

        tbl_addr = 12'h123;
        sw_write(8'h06);
        chk("R4 accepted write rdata", reg_rdata, 8'h06);
        chk("R4 busy set", busy, 1);
        chk("R4 request", {mem_req, mem_op, mem_space, mem_addr}, {1'b1, 2'd1, 2'd0, 12'h123});
        sw_write(8'h90);
        chk("R4 req one cycle", mem_req, 0);
        chk("R8 R9 busy write ignored", reg_rdata, 8'h02);
        mem_done = 1'b1; tick(); mem_done = 1'b0;
        chk("R5 done clears", {busy, reg_rdata}, {1'b0, 8'h00});
        mem_done = 1'b1; tick(); mem_done = 1'b0;
        chk("R5 idle done ignored", {busy, mem_req, reg_rdata}, {1'b0, 1'b0, 8'h00});

        sw_write(8'h04);
        sw_write(8'hD6);
        chk("R12 cfg overrides prog, erase op", {mem_op, mem_space}, {2'd2, 2'd2});
        abort_i = 1'b1; mem_done = 1'b1; tick(); abort_i = 1'b0; mem_done = 1'b0;
        chk("R10 abort beats done", {busy, reg_rdata}, {1'b0, 8'hDC});
        abort_i = 1'b1; tick(); abort_i = 1'b0;
        chk("R10 idle abort ignored", reg_rdata, 8'hDC);
        sw_write(8'h84);
        chk("R11 software clears err", reg_rdata, 8'h84);

        sw_write(8'h86);
        chk("R12 program space write", {mem_op, mem_space}, {2'd1, 2'd1});
        mem_done = 1'b1; tick(); mem_done = 1'b0;
        sw_write(8'h96);
        chk("R4 erase op", mem_op, 2'd2);
        mem_done = 1'b1; tick(); mem_done = 1'b0;
        chk("R5 erase bit cleared on completion", reg_rdata, 8'h84);

        tbl_addr = 12'h2C7;
        sw_write(8'h05);
        chk("R6 read started", {reg_rdata, mem_req, mem_op, mem_space}, {8'h05, 1'b1, 2'd0, 2'd0});
        tick();
        chk("R6 read bit self-clears", reg_rdata, 8'h04);
        chk("R6 read data captured", rd_data, memf(12'h2C7));
        sw_write(8'h45);
        chk("R7 read refused cfg", {reg_rdata, mem_req}, {8'h44, 1'b0});
        chk("R7 rd_data unchanged", rd_data, memf(12'h2C7));
        sw_write(8'h07);
        chk("R7 write wins over read", {reg_rdata, mem_op}, {8'h06, 2'd1});
        mem_done = 1'b1; tick(); mem_done = 1'b0;

        sw_write(8'h06);
        reg_wr_en = 1'b1; reg_wdata = 8'h00; abort_i = 1'b1;
        tick();
        reg_wr_en = 1'b0; abort_i = 1'b0;
        chk("R11 hardware set beats software clear", reg_rdata, 8'h08);

        hold = 0;
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (hold > 0) begin
                hold--; rst_n = 1'b0;
            end else if (r[7:0] == 8'd3) begin
                hold = 1; rst_n = 1'b0;
            end else begin
                rst_n = 1'b1;
            end
            reg_wr_en = (r[10:8] < 3'd3);
            reg_wdata = $urandom;
            if (r[11]) reg_wdata[2] = 1'b1;
            if (r[12]) reg_wdata[7:6] = 2'b00;
            tbl_addr  = $urandom;
            mem_done  = (r[15:13] < 3'd2);
            abort_i   = (r[20:16] == 5'd0);
            tick();
        end
        rst_n = 1'b1; reg_wr_en = 1'b0; mem_done = 1'b0; abort_i = 1'b0;
        repeat (3) tick();
        finish_run();
    end
endmodule